// File: doc/BRIEF.md
# Split Approximate Adder with OR-Based Low Section

This block adds two unsigned operands while trading accuracy in the least significant bits for a shorter carry path. The operand width is cut at a parameterised point. Below that point each result bit is the OR of the two operand bits at that position, and no carry ripples through this section. Above it, an exact ripple-carry adder forms the remaining sum bits and the carry-out. The only carry that crosses the cut is the AND of the two operand bits just below it.

The adder is meant for error-tolerant datapaths such as filters and pixel pipelines. There the small, bounded error in the low bits costs less than a full-width carry chain. A parameter selects whether the result passes straight through or is captured in an output register. When it is captured, a valid flag moves through the register alongside the data. Setting the cut to zero gives an exact adder. Setting it to the full width removes the exact section, so the carry-out becomes the AND carry.

Top module: `or_lsb_adder`

## Requirements
- R1: For every bit position i below LOW_W, sum[i] equals op_a[i] OR op_b[i].
- R2: The exact upper section receives a carry-in equal to op_a[LOW_W-1] AND op_b[LOW_W-1]. With LOW_W = 0, this carry-in is 0.
- R3: No other carry formed inside the low section affects any result bit. For example, with LOW_W = 6, 0x0001 + 0x0001 gives sum 0x0001.
- R4: {carry_out, sum[WIDTH-1:LOW_W]} equals op_a[WIDTH-1:LOW_W] + op_b[WIDTH-1:LOW_W] + the R2 carry-in, computed exactly.
- R5: With LOW_W = 0, {carry_out, sum} equals op_a + op_b exactly, so the error distance is 0.
- R6: With LOW_W = WIDTH, sum is the bitwise OR of the operands and carry_out equals op_a[WIDTH-1] AND op_b[WIDTH-1].
- R7: In registered mode, sum and carry_out take the result of a valid input at the first rising edge after it is presented. out_valid is high in exactly the cycle that result is shown.
- R8: In registered mode, a cycle with in_valid low leaves sum and carry_out unchanged and drives out_valid low in the following cycle.
- R9: In registered mode, reset drives out_valid, sum and carry_out to 0. Reset is applied asynchronously and released on a clock edge.
- R10: In combinational mode, sum, carry_out and out_valid follow op_a, op_b and in_valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | sum and carry_out hold a fresh result |
| sum | output | WIDTH | Approximate sum |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The hardest case to reach from the ports is the single carry that crosses the cut. It needs both operand bits at position LOW_W-1 set. The bench then has to tell apart a carry that was discarded lower down from this carry that was kept. Random operands set that pair only one time in four, and rarely together with a full upper carry chain. Directed vectors therefore place ones at LOW_W-1 and at the lowest bit on their own. They also pair the crossing carry with an all-ones upper field, which drives the carry-out. Random vectors then compare all four configurations against a bit-level model and report the error distance from the exact sum.

// File: rtl/or_add_pkg.sv
package or_add_pkg;
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;
endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] stage_q;
  logic [1:0] stage_nxt;

  always_comb begin
    stage_nxt = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_nxt;
  end

  assign rst_q = stage_q[1];
endmodule

// File: rtl/lsb_or_stage.sv
module lsb_or_stage #(
  parameter int LW = 4
) (
  input  logic [LW-1:0] a_lo,
  input  logic [LW-1:0] b_lo,
  output logic [LW-1:0] s_lo,
  output logic          c_up
);
  genvar i;
  generate
    for (i = 0; i < LW; i++) begin : g_bit
      assign s_lo[i] = a_lo[i] | b_lo[i];
    end
  endgenerate

  // Only the top pair of the low section feeds the exact section.
  assign c_up = a_lo[LW-1] & b_lo[LW-1];
endmodule

// File: rtl/msb_ripple_stage.sv
module msb_ripple_stage #(
  parameter int HW = 8
) (
  input  logic [HW-1:0] a_hi,
  input  logic [HW-1:0] b_hi,
  input  logic          c_in,
  output logic [HW-1:0] s_hi,
  output logic          c_out
);
  logic [HW:0] chain;
  assign chain[0] = c_in;

  genvar i;
  generate
    for (i = 0; i < HW; i++) begin : g_fa
      logic half_x;
      assign half_x      = a_hi[i] ^ b_hi[i];
      assign s_hi[i]     = half_x ^ chain[i];
      assign chain[i+1]  = (a_hi[i] & b_hi[i]) | (half_x & chain[i]);
    end
  endgenerate

  assign c_out = chain[HW];
endmodule

// File: rtl/result_stage.sv
module result_stage
  import or_add_pkg::*;
#(
  parameter int        W    = 17,
  parameter out_mode_e MODE = OUT_REG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  input  logic [W-1:0] d_in,
  output logic         v_out,
  output logic [W-1:0] d_out
);
  generate
    if (MODE == OUT_REG) begin : g_reg
      logic [W-1:0] d_q, d_nxt;
      logic         v_q;

      always_comb begin
        d_nxt = v_in ? d_in : d_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_q <= '0;
          v_q <= 1'b0;
        end else begin
          d_q <= d_nxt;
          v_q <= v_in;
        end
      end

      assign d_out = d_q;
      assign v_out = v_q;
    end else begin : g_comb
      assign d_out = d_in;
      assign v_out = v_in;
    end
  endgenerate
endmodule

// File: rtl/or_lsb_adder.sv
module or_lsb_adder
  import or_add_pkg::*;
#(
  parameter int        WIDTH = 16,
  parameter int        LOW_W = 6,
  parameter out_mode_e MODE  = OUT_REG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int HI_W = WIDTH - LOW_W;
  localparam int RES_W = WIDTH + 1;

  logic [WIDTH-1:0] sum_c;
  logic             cout_c;
  logic             cross_c;
  logic             rst_q;
  logic [RES_W-1:0] res_q;

  rst_release_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  generate
    if (LOW_W > 0) begin : g_lo
      lsb_or_stage #(.LW(LOW_W)) u_lo (
        .a_lo (op_a[LOW_W-1:0]),
        .b_lo (op_b[LOW_W-1:0]),
        .s_lo (sum_c[LOW_W-1:0]),
        .c_up (cross_c)
      );
    end else begin : g_nolo
      assign cross_c = 1'b0;
    end

    if (HI_W > 0) begin : g_hi
      msb_ripple_stage #(.HW(HI_W)) u_hi (
        .a_hi  (op_a[WIDTH-1:LOW_W]),
        .b_hi  (op_b[WIDTH-1:LOW_W]),
        .c_in  (cross_c),
        .s_hi  (sum_c[WIDTH-1:LOW_W]),
        .c_out (cout_c)
      );
    end else begin : g_nohi
      assign cout_c = cross_c;
    end
  endgenerate

  result_stage #(.W(RES_W), .MODE(MODE)) u_out (
    .clk   (clk),
    .rst_n (rst_q),
    .v_in  (in_valid),
    .d_in  ({cout_c, sum_c}),
    .v_out (out_valid),
    .d_out (res_q)
  );

  assign sum       = res_q[WIDTH-1:0];
  assign carry_out = res_q[WIDTH];

  generate
    if (MODE == OUT_REG) begin : g_chk
      // R7
      valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_q)
        in_valid |=> out_valid);
      // R8
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
        !in_valid |=> (!out_valid && $stable({carry_out, sum})));
      if (LOW_W > 0) begin : g_lo_chk
        // R1
        low_or_chk: assert property (@(posedge clk) disable iff (!rst_q)
          in_valid |=> sum[LOW_W-1:0] == $past(op_a[LOW_W-1:0] | op_b[LOW_W-1:0]));
      end
      if (LOW_W > 0 && HI_W > 0) begin : g_hi_chk
        // R4
        upper_exact_chk: assert property (@(posedge clk) disable iff (!rst_q)
          in_valid |=> {carry_out, sum[WIDTH-1:LOW_W]} ==
            $past({1'b0, op_a[WIDTH-1:LOW_W]} + {1'b0, op_b[WIDTH-1:LOW_W]}
                  + {{HI_W{1'b0}}, op_a[LOW_W-1] & op_b[LOW_W-1]}));
      end
      if (LOW_W == 0) begin : g_exact_chk
        // R5
        exact_sum_chk: assert property (@(posedge clk) disable iff (!rst_q)
          in_valid |=> {carry_out, sum} == $past({1'b0, op_a} + {1'b0, op_b}));
      end
      if (HI_W == 0) begin : g_full_chk
        // R6
        full_and_carry_chk: assert property (@(posedge clk) disable iff (!rst_q)
          in_valid |=> carry_out == $past(op_a[WIDTH-1] & op_b[WIDTH-1]));
      end
    end
  endgenerate
endmodule

// File: tb/or_lsb_adder_tb_top.sv
module or_lsb_adder_tb_top;
  import or_add_pkg::*;

  localparam int W  = 16;
  localparam int LW = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;

  logic         v_m, v_e, v_f, v_c;
  logic [W-1:0] s_m, s_e, s_f, s_c;
  logic         c_m, c_e, c_f, c_c;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  longint ed_total = 0;
  int ed_max = 0;
  int ed_n = 0;

  always #10 clk = ~clk;

  or_lsb_adder #(.WIDTH(W), .LOW_W(LW), .MODE(OUT_REG)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(v_m), .sum(s_m), .carry_out(c_m));
  or_lsb_adder #(.WIDTH(W), .LOW_W(0), .MODE(OUT_REG)) dut_exact (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(v_e), .sum(s_e), .carry_out(c_e));
  or_lsb_adder #(.WIDTH(W), .LOW_W(W), .MODE(OUT_REG)) dut_full (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(v_f), .sum(s_f), .carry_out(c_f));
  or_lsb_adder #(.WIDTH(W), .LOW_W(LW), .MODE(OUT_COMB)) dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(v_c), .sum(s_c), .carry_out(c_c));

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input int lw);
    logic [W:0] r, hi;
    logic cr;
    r = '0;
    for (int i = 0; i < lw; i++) r[i] = a[i] | b[i];
    cr = (lw > 0) ? (a[lw-1] & b[lw-1]) : 1'b0;
    hi = ({1'b0, a} >> lw) + ({1'b0, b} >> lw) + {{W{1'b0}}, cr};
    r = r | (hi << lw);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W:0] act,
                     input logic [W:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%05h expected=0x%05h", req, act, exp);
    end
  endtask

  // Present one vector; check the combinational instance in the same cycle
  // and the registered instances after the capturing edge.
  task automatic t_vector(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] em, ee, ef;
    int ed;
    em = model(a, b, LW);
    ee = {1'b0, a} + {1'b0, b};
    ef = model(a, b, W);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    #2;
    chk({c_c, s_c} == em && v_c, "R10 comb result", {c_c, s_c}, em);
    @(negedge clk);
    in_valid = 1'b0;
    chk({c_m, s_m} == em, "R1/R2/R4 split result", {c_m, s_m}, em);
    chk(v_m == 1'b1, "R7 out_valid aligned", {16'd0, v_m}, 17'd1);
    chk({c_e, s_e} == ee, "R5 exact when LOW_W=0", {c_e, s_e}, ee);
    chk({c_f, s_f} == ef, "R6 all-OR when LOW_W=WIDTH", {c_f, s_f}, ef);
    ed = int'(ee > em ? ee - em : em - ee);
    ed_total += ed;
    ed_n++;
    if (ed > ed_max) ed_max = ed;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(v_m == 1'b0 && s_m == '0 && c_m == 1'b0, "R9 reset state",
        {c_m, s_m}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(v_m == 1'b0, "R9 idle after release", {16'd0, v_m}, '0);
  endtask

  task automatic t_low_section();
    t_vector(16'h0015, 16'h002A);
    chk({c_m, s_m} == 17'h0003F, "R1 disjoint low bits", {c_m, s_m}, 17'h0003F);
    t_vector(16'h0001, 16'h0001);
    chk({c_m, s_m} == 17'h00001, "R3 low carry dropped", {c_m, s_m}, 17'h00001);
    t_vector(16'h001F, 16'h001F);
    chk({c_m, s_m} == 17'h0001F, "R3 run of low carries dropped", {c_m, s_m}, 17'h0001F);
  endtask

  task automatic t_cross_carry();
    t_vector(16'h0020, 16'h0020);
    chk({c_m, s_m} == 17'h00060, "R2 crossing carry kept", {c_m, s_m}, 17'h00060);
    t_vector(16'hFFE0, 16'h0020);
    chk({c_m, s_m} == 17'h10020, "R4 carry-out via crossing carry", {c_m, s_m}, 17'h10020);
    t_vector(16'hFFFF, 16'hFFFF);
    chk({c_f, s_f} == 17'h1FFFF, "R6 AND carry-out", {c_f, s_f}, 17'h1FFFF);
    t_vector(16'h8000, 16'h7FFF);
    chk({c_f, s_f} == 17'h0FFFF, "R6 no carry-out", {c_f, s_f}, 17'h0FFFF);
  endtask

  task automatic t_hold();
    logic [W:0] held;
    t_vector(16'h1234, 16'h4321);
    held = {c_m, s_m};
    @(negedge clk);
    op_a = 16'hAAAA; op_b = 16'h5555;
    @(negedge clk);
    chk({c_m, s_m} == held, "R8 result held while idle", {c_m, s_m}, held);
    chk(v_m == 1'b0, "R8 out_valid low while idle", {16'd0, v_m}, '0);
    @(negedge clk);
    chk({c_m, s_m} == held, "R8 still held", {c_m, s_m}, held);
  endtask

  task automatic t_random();
    for (int k = 0; k < 300; k++) begin
      t_vector(W'($urandom()), W'($urandom()));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_low_section();
    t_cross_carry();
    t_hold();
    t_random();
    $display("error distance (LOW_W=%0d): max=%0d mean=%0d over %0d vectors",
             LW, ed_max, int'(ed_total / ed_n), ed_n);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule